// File: doc/BRIEF.md
# Scanout Channel Configuration Bank with Shadowed Commit

This block holds the settings for one scanout channel. It also hands the active copy of those settings to a pixel fetch engine that sits next to it. Software writes the enable bit, the pixel format, the two active sizes and the stride into shadow copies. These posted values do not reach the active set when they are written. They reach it all together, in one clock edge, when software writes the frame base address. The base write is the commit point, so the scanout engine never sees a half-updated mode.

The line offset register has its own commit rule. Its written value waits in a small two-state machine. The states are LO_SYNCED, where the active value equals the shadow, and LO_ARMED, where a newer value is waiting. A write moves the machine from LO_SYNCED to LO_ARMED. In LO_ARMED a `vblank_start` pulse copies the shadow to the active value. The machine then returns to LO_SYNCED, or stays in LO_ARMED if a new write lands in that same cycle.

Each written value is checked against fixed limits. These are the maximum active sizes, an alignment mask for the stride and the base, and a mask of the allowed formats. A value that breaks a limit stays in its shadow and sets a sticky error flag. That field then keeps its old active value at the next commit.

Top module: `scan_cfg_bank`

## Requirements
- R1: Writes to index 0 (control, bit 0 = enable), 1 (format), 2 (horizontal active), 3 (vertical active) and 4 (stride) change only the shadow copies. No active output changes on such a write.
- R2: A write to index 5 (base) updates, at that same clock edge, `act_base` with the written value and every other active field except line offset with its current shadow value. Only fields whose shadow is valid are updated.
- R3: A write to index 6 (line offset) reaches `act_line_off` only at the first `vblank_start` pulse after the write edge. A base write does not move it. If a line offset write and `vblank_start` arrive in the same cycle while a value is already waiting, the waiting value commits and the new one waits for the next pulse.
- R4: Horizontal active holds pixels minus one and must not exceed MAX_H (1919 by default). Vertical active holds lines minus one and must not exceed MAX_V (1079). A larger value sets the error flag and is not committed.
- R5: The stride and the base must have a 0 in every bit that is 1 in ALIGN_MASK (0x1f by default, so multiples of 0x20). A misaligned value sets the error flag and is not committed.
- R6: The format must have exactly one bit set, and that bit must also be set in VALID_FMT (0x5c by default). Bits 0 to 7 mean RGB555, BGR555, RGB565, BGR565, RGB888, BGR888, RGBX8888 and BGRX8888. Any other value sets the error flag and is not committed.
- R7: After reset the channel is disabled, every active output is 0 and `cfg_error` is 0.
- R8: `cfg_error` is set by any write that breaks R4, R5 or R6. It stays set until a write to index 7 with bit 0 = 1, and a write with bit 0 = 0 leaves it set. Index 7 also reads the flag in bit 0.
- R9: Reads of indices 0 to 4 and 6 return the shadow values, including values that were rejected. A read of index 5 returns the active base.
- R10: Indices 8, 9, 10 and 11 read MAX_H, MAX_V, VALID_FMT and ALIGN_MASK. Writes to them have no effect, and unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register index for the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| act_enable | output | 1 | Active channel enable |
| act_format | output | 8 | Active one-hot pixel format |
| act_hsize | output | 16 | Active horizontal size (pixels minus one) |
| act_vsize | output | 16 | Active vertical size (lines minus one) |
| act_stride | output | 32 | Active stride in bytes |
| act_base | output | 32 | Active frame base offset in bytes |
| act_line_off | output | 32 | Active line offset in bytes |
| cfg_error | output | 1 | Sticky constraint-violation flag |

## Verification
The bench checks the active outputs after posted writes and before any base write. A design that leaked posted values early would change the scanout mode in the middle of a frame. It tests the size limits exactly at MAX and at MAX+1, misaligned strides and bases, formats with two bits set, and formats outside the valid mask. A wrong boundary or a missing check would commit an illegal mode. It drives a line offset write in the same cycle as a `vblank_start` pulse while another value is waiting. A design with a wrong LO_ARMED transition would either skip the waiting value or commit the new one a frame early. It also shows that a rejected field keeps its old active value while the other fields in the same base write still commit.

// File: rtl/scb_pkg.sv
package scb_pkg;
    typedef enum logic [3:0] {
        RI_CTRL   = 4'd0,
        RI_FMT    = 4'd1,
        RI_HACT   = 4'd2,
        RI_VACT   = 4'd3,
        RI_STRIDE = 4'd4,
        RI_BASE   = 4'd5,
        RI_LOFF   = 4'd6,
        RI_ERR    = 4'd7,
        RI_HMAX   = 4'd8,
        RI_VMAX   = 4'd9,
        RI_FMTOK  = 4'd10,
        RI_ALIGN  = 4'd11
    } reg_idx_e;

    typedef enum logic {
        LO_SYNCED = 1'b0,
        LO_ARMED  = 1'b1
    } lo_state_e;
endpackage

// File: rtl/scb_field_check.sv
module scb_field_check
    import scb_pkg::*;
#(
    parameter int unsigned DW         = 32,
    parameter int unsigned MAX_H      = 1919,
    parameter int unsigned MAX_V      = 1079,
    parameter logic [DW-1:0] ALIGN_MASK = 'h1f,
    parameter logic [7:0]  VALID_FMT  = 8'h5c
) (
    input  reg_idx_e        idx,
    input  logic [DW-1:0]   wdata,
    output logic            viol
);
    localparam logic [DW-1:0] FMT_OK_W = DW'(VALID_FMT);
    localparam logic [DW-1:0] HMAX_W   = DW'(MAX_H);
    localparam logic [DW-1:0] VMAX_W   = DW'(MAX_V);

    always_comb begin
        viol = 1'b0;
        unique case (idx)
            RI_FMT:    viol = ($countones(wdata) != 1) || ((wdata & ~FMT_OK_W) != '0);
            RI_HACT:   viol = (wdata > HMAX_W);
            RI_VACT:   viol = (wdata > VMAX_W);
            RI_STRIDE: viol = ((wdata & ALIGN_MASK) != '0);
            RI_BASE:   viol = ((wdata & ALIGN_MASK) != '0);
            default:   viol = 1'b0;
        endcase
    end
endmodule

// File: rtl/scb_lo_sync.sv
module scb_lo_sync
    import scb_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_wr,
    input  logic [DW-1:0] lo_wdata,
    input  logic          vblank_start,
    output logic [DW-1:0] lo_shadow,
    output logic [DW-1:0] lo_active
);
    lo_state_e state_q, state_d;
    logic      commit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LO_SYNCED;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            LO_SYNCED: begin
                if (lo_wr) state_d = LO_ARMED;
            end
            LO_ARMED: begin
                if (vblank_start) begin
                    commit = 1'b1;
                    if (!lo_wr) state_d = LO_SYNCED;
                end
            end
            default: state_d = LO_SYNCED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_shadow <= '0;
            lo_active <= '0;
        end else begin
            if (lo_wr)  lo_shadow <= lo_wdata;
            if (commit) lo_active <= lo_shadow;
        end
    end

    // R3: the active offset moves only on a vertical blank start pulse
    a_r3_hold_outside_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_start |=> $stable(lo_active));

    // R3: a waiting value lands at the pulse
    a_r3_armed_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LO_ARMED && vblank_start) |=> (lo_active == $past(lo_shadow)));
endmodule

// File: rtl/scan_cfg_bank.sv
module scan_cfg_bank
    import scb_pkg::*;
#(
    parameter int unsigned   DW         = 32,
    parameter int unsigned   SZW        = 16,
    parameter int unsigned   MAX_H      = 1919,
    parameter int unsigned   MAX_V      = 1079,
    parameter logic [DW-1:0] ALIGN_MASK = 'h1f,
    parameter logic [7:0]    VALID_FMT  = 8'h5c
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [3:0]     rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           vblank_start,
    output logic           act_enable,
    output logic [7:0]     act_format,
    output logic [SZW-1:0] act_hsize,
    output logic [SZW-1:0] act_vsize,
    output logic [DW-1:0]  act_stride,
    output logic [DW-1:0]  act_base,
    output logic [DW-1:0]  act_line_off,
    output logic           cfg_error
);
    localparam logic [SZW-1:0] HMAX_S = SZW'(MAX_H);
    localparam logic [SZW-1:0] VMAX_S = SZW'(MAX_V);

    reg_idx_e wr_idx, rd_idx;
    assign wr_idx = reg_idx_e'(wr_addr);
    assign rd_idx = reg_idx_e'(rd_addr);

    logic           viol;
    logic           posted_wr, base_wr, lo_wr, err_clr;
    logic           sh_en;
    logic [7:0]     sh_fmt;
    logic [SZW-1:0] sh_h, sh_v;
    logic [DW-1:0]  sh_stride;
    logic           bad_fmt, bad_h, bad_v, bad_stride;
    logic [DW-1:0]  lo_shadow;

    scb_field_check #(
        .DW(DW), .MAX_H(MAX_H), .MAX_V(MAX_V),
        .ALIGN_MASK(ALIGN_MASK), .VALID_FMT(VALID_FMT)
    ) u_check (
        .idx(wr_idx), .wdata(wr_data), .viol(viol)
    );

    scb_lo_sync #(.DW(DW)) u_lo (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .lo_wdata(wr_data),
        .vblank_start(vblank_start), .lo_shadow(lo_shadow), .lo_active(act_line_off)
    );

    always_comb begin
        posted_wr = 1'b0;
        base_wr   = 1'b0;
        lo_wr     = 1'b0;
        err_clr   = 1'b0;
        if (wr_en) begin
            unique case (wr_idx)
                RI_CTRL, RI_FMT, RI_HACT, RI_VACT, RI_STRIDE: posted_wr = 1'b1;
                RI_BASE: base_wr = 1'b1;
                RI_LOFF: lo_wr   = 1'b1;
                RI_ERR:  err_clr = wr_data[0];
                default: ;
            endcase
        end
    end

    // shadow copies and their validity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en      <= 1'b0;
            sh_fmt     <= '0;
            sh_h       <= '0;
            sh_v       <= '0;
            sh_stride  <= '0;
            bad_fmt    <= 1'b0;
            bad_h      <= 1'b0;
            bad_v      <= 1'b0;
            bad_stride <= 1'b0;
        end else if (posted_wr) begin
            unique case (wr_idx)
                RI_CTRL:   sh_en <= wr_data[0];
                RI_FMT:    begin sh_fmt    <= wr_data[7:0];     bad_fmt    <= viol; end
                RI_HACT:   begin sh_h      <= wr_data[SZW-1:0]; bad_h      <= viol; end
                RI_VACT:   begin sh_v      <= wr_data[SZW-1:0]; bad_v      <= viol; end
                RI_STRIDE: begin sh_stride <= wr_data;          bad_stride <= viol; end
                default: ;
            endcase
        end
    end

    // active set, committed on a base write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_enable <= 1'b0;
            act_format <= '0;
            act_hsize  <= '0;
            act_vsize  <= '0;
            act_stride <= '0;
            act_base   <= '0;
        end else if (base_wr) begin
            act_enable <= sh_en;
            if (!viol)       act_base   <= wr_data;
            if (!bad_fmt)    act_format <= sh_fmt;
            if (!bad_h)      act_hsize  <= sh_h;
            if (!bad_v)      act_vsize  <= sh_v;
            if (!bad_stride) act_stride <= sh_stride;
        end
    end

    // sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n)              cfg_error <= 1'b0;
        else if (wr_en && viol)  cfg_error <= 1'b1;
        else if (err_clr)        cfg_error <= 1'b0;
    end

    // read path
    always_comb begin
        rd_data = '0;
        unique case (rd_idx)
            RI_CTRL:   rd_data = DW'(sh_en);
            RI_FMT:    rd_data = DW'(sh_fmt);
            RI_HACT:   rd_data = DW'(sh_h);
            RI_VACT:   rd_data = DW'(sh_v);
            RI_STRIDE: rd_data = sh_stride;
            RI_BASE:   rd_data = act_base;
            RI_LOFF:   rd_data = lo_shadow;
            RI_ERR:    rd_data = DW'(cfg_error);
            RI_HMAX:   rd_data = DW'(MAX_H);
            RI_VMAX:   rd_data = DW'(MAX_V);
            RI_FMTOK:  rd_data = DW'(VALID_FMT);
            RI_ALIGN:  rd_data = ALIGN_MASK;
            default:   rd_data = '0;
        endcase
    end

    // R1: posted writes leave the active set untouched
    a_r1_posted_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr <= 4'd4) |=> ($stable(act_enable) && $stable(act_format) &&
        $stable(act_hsize) && $stable(act_vsize) && $stable(act_stride) && $stable(act_base)));

    // R2: an aligned base write lands at once
    a_r2_base_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd5 && (wr_data & ALIGN_MASK) == '0) |=> (act_base == $past(wr_data)));

    // R4: active sizes never exceed the maxima
    a_r4_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hsize <= HMAX_S) && (act_vsize <= VMAX_S));

    // R5: active stride and base are aligned
    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_stride & ALIGN_MASK) == '0) && ((act_base & ALIGN_MASK) == '0));

    // R6: active format is one legal bit or empty
    a_r6_fmt_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_format) && ((act_format & ~VALID_FMT) == 8'h00));

    // R8: the error flag holds until cleared
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_error && !(wr_en && wr_addr == 4'd7 && wr_data[0])) |=> cfg_error);
endmodule

// File: tb/sim_scan_cfg_bank.sv
module sim_scan_cfg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        vblank_start = 1'b0;
    logic        act_enable;
    logic [7:0]  act_format;
    logic [15:0] act_hsize, act_vsize;
    logic [31:0] act_stride, act_base, act_line_off;
    logic        cfg_error;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scan_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vblank_start(vblank_start),
        .act_enable(act_enable), .act_format(act_format), .act_hsize(act_hsize),
        .act_vsize(act_vsize), .act_stride(act_stride), .act_base(act_base),
        .act_line_off(act_line_off), .cfg_error(cfg_error)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vb();
        @(negedge clk);
        vblank_start = 1'b1;
        @(negedge clk);
        vblank_start = 1'b0;
    endtask

    task automatic wr_vb(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; vblank_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; vblank_start = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        chk("R7 enable", 32'(act_enable), 0);
        chk("R7 format", 32'(act_format), 0);
        chk("R7 hsize", 32'(act_hsize), 0);
        chk("R7 base", act_base, 0);
        chk("R7 line_off", act_line_off, 0);
        chk("R7 error", 32'(cfg_error), 0);
    endtask

    task automatic t_posted_commit();
        logic [31:0] v;
        wr(4'd0, 1); wr(4'd1, 32'h04); wr(4'd2, 639); wr(4'd3, 479); wr(4'd4, 2560);
        chk("R1 enable held", 32'(act_enable), 0);
        chk("R1 format held", 32'(act_format), 0);
        chk("R1 hsize held", 32'(act_hsize), 0);
        chk("R1 stride held", act_stride, 0);
        rd(4'd2, v); chk("R9 hact shadow", v, 639);
        rd(4'd1, v); chk("R9 fmt shadow", v, 32'h04);
        wr(4'd5, 32'h1000);
        chk("R2 enable", 32'(act_enable), 1);
        chk("R2 format", 32'(act_format), 32'h04);
        chk("R2 hsize", 32'(act_hsize), 639);
        chk("R2 vsize", 32'(act_vsize), 479);
        chk("R2 stride", act_stride, 2560);
        chk("R2 base", act_base, 32'h1000);
        chk("R4 no error", 32'(cfg_error), 0);
    endtask

    task automatic t_base_align();
        logic [31:0] v;
        wr(4'd5, 32'h1004);
        chk("R5 misaligned base kept", act_base, 32'h1000);
        chk("R5 error set", 32'(cfg_error), 1);
        rd(4'd5, v); chk("R9 base reads active", v, 32'h1000);
        rd(4'd7, v); chk("R8 error readable", v, 1);
        wr(4'd7, 0);
        chk("R8 zero write keeps", 32'(cfg_error), 1);
        wr(4'd7, 1);
        chk("R8 cleared", 32'(cfg_error), 0);
    endtask

    task automatic t_sizes();
        logic [31:0] v;
        wr(4'd2, 1920);
        chk("R4 hact over max flagged", 32'(cfg_error), 1);
        rd(4'd2, v); chk("R9 rejected shadow", v, 1920);
        wr(4'd7, 1);
        wr(4'd5, 32'h2000);
        chk("R4 hsize not committed", 32'(act_hsize), 639);
        chk("R2 base still commits", act_base, 32'h2000);
        wr(4'd2, 1919); wr(4'd3, 1079); wr(4'd5, 32'h2000);
        chk("R4 hact at max", 32'(act_hsize), 1919);
        chk("R4 vact at max", 32'(act_vsize), 1079);
        chk("R4 at max no error", 32'(cfg_error), 0);
        wr(4'd3, 1080);
        chk("R4 vact over max flagged", 32'(cfg_error), 1);
        wr(4'd7, 1);
        wr(4'd5, 32'h2000);
        chk("R4 vsize not committed", 32'(act_vsize), 1079);
    endtask

    task automatic t_format();
        wr(4'd1, 32'h0c);
        chk("R6 two bits flagged", 32'(cfg_error), 1);
        wr(4'd7, 1);
        wr(4'd1, 32'h01);
        chk("R6 RGB555 not in mask flagged", 32'(cfg_error), 1);
        wr(4'd7, 1);
        wr(4'd5, 32'h2000);
        chk("R6 bad format not committed", 32'(act_format), 32'h04);
        wr(4'd1, 32'h00);
        chk("R6 empty flagged", 32'(cfg_error), 1);
        wr(4'd7, 1);
        wr(4'd1, 32'h40);
        chk("R6 RGBX8888 accepted", 32'(cfg_error), 0);
        wr(4'd5, 32'h2000);
        chk("R6 RGBX8888 committed", 32'(act_format), 32'h40);
    endtask

    task automatic t_stride_enable();
        wr(4'd4, 32'h21);
        chk("R5 stride flagged", 32'(cfg_error), 1);
        wr(4'd7, 1);
        wr(4'd0, 0);
        wr(4'd5, 32'h3000);
        chk("R5 stride not committed", act_stride, 2560);
        chk("R2 disable commits", 32'(act_enable), 0);
        chk("R2 base", act_base, 32'h3000);
    endtask

    task automatic t_line_offset();
        logic [31:0] v;
        wr(4'd6, 32'h80);
        chk("R3 not before vblank", act_line_off, 0);
        rd(4'd6, v); chk("R9 line offset shadow", v, 32'h80);
        wr(4'd5, 32'h3000);
        chk("R3 base write ignores offset", act_line_off, 0);
        vb();
        chk("R3 commit at vblank", act_line_off, 32'h80);
        wr(4'd6, 32'h90);
        wr_vb(4'd6, 32'hA0);
        chk("R3 waiting value on collision", act_line_off, 32'h90);
        vb();
        chk("R3 new value next vblank", act_line_off, 32'hA0);
        vb();
        chk("R3 idle vblank holds", act_line_off, 32'hA0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(4'd8, 5);
        rd(4'd8, v); chk("R10 hmax", v, 1919);
        rd(4'd9, v); chk("R10 vmax", v, 1079);
        rd(4'd10, v); chk("R10 valid fmt", v, 32'h5c);
        rd(4'd11, v); chk("R10 align", v, 32'h1f);
        rd(4'd12, v); chk("R10 unused", v, 0);
        chk("R10 no error from ro write", 32'(cfg_error), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_posted_commit();
        t_base_align();
        t_sizes();
        t_format();
        t_stride_enable();
        t_line_offset();
        t_readonly();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule